// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is an I2C target that lets an external bus master read and write a 256-entry, 8-bit register file over two wires: a clock line (SCL) and an open-drain data line (SDA). SCL and SDA are sampled by a fast system clock through a two-flop synchronizer. Bus events (START, STOP, SCL edges) are found by edge detection on the synchronized lines. The SDA output is modelled only as a pull-low enable, so the block never drives SDA high.

A write transaction sends the device address with R/W = 0, then a sub-address byte, then any number of data bytes. The data bytes land in consecutive registers. A read transaction sends the device address with R/W = 1 and no sub-address. Data comes back starting at the register pointer left by the last transaction. The pointer steps by one after every data byte, in both directions. To read from a chosen location, the master first issues a write that carries only the sub-address.

The device address is picked by strap inputs. With `cfg_multi_id` low, the block answers only to 0xC0 (write) and 0xC1 (read). With `cfg_multi_id` high, the 3-bit `cfg_id_sel` selects write address 0xC0 + 4·sel, and the read address is that value + 1. The board should tie `cfg_multi_id` low when it is not used. Repeated START is not supported: a START in the middle of a transaction abandons that transaction and begins a new one.

The controller has nine named states:
- IDLE: waits for START.
- ADDR: shifts in the address byte.
- ADDR_ACK: acknowledges the address byte.
- SUB: shifts in the sub-address byte.
- SUB_ACK: acknowledges the sub-address byte.
- WDATA: shifts in a data byte.
- WDATA_ACK: acknowledges a data byte.
- RDATA: shifts out a data byte.
- RACK: samples the master's acknowledge.

The transitions are:
- any state → ADDR on START.
- any state → IDLE on STOP.
- ADDR → ADDR_ACK on an address match.
- ADDR → IDLE on an address mismatch.
- ADDR_ACK → SUB (write) or ADDR_ACK → RDATA (read), at the SCL fall that ends the ninth clock.
- SUB → SUB_ACK after 8 bits.
- SUB_ACK → WDATA.
- WDATA → WDATA_ACK after 8 bits.
- WDATA_ACK → WDATA.
- RDATA → RACK after the eighth SCL fall.
- RACK → RDATA when the master sends ACK.
- RACK → IDLE when the master sends NACK.

Top module: `i2c_regslave`

## Requirements
- R1: A falling SDA while SCL is high is a START and moves the block to address reception. A rising SDA while SCL is high is a STOP; it returns the block to idle with SDA released.
- R2: With `cfg_multi_id` low, only address bytes whose upper 7 bits equal 0x60 (0xC0 write, 0xC1 read) are acknowledged.
- R3: With `cfg_multi_id` high, the write address is 0xC0 + 4·`cfg_id_sel` and the read address is that value + 1. Other addresses, including 0xC0 when sel ≠ 0, get no acknowledge.
- R4: After an address mismatch the block never pulls SDA low, and it writes no register until the next START.
- R5: The block pulls SDA low during the ninth SCL clock after a matching address byte, after the sub-address byte and after each data byte written.
- R6: In a write, the byte after the address loads the pointer. Each following byte, received MSB first, is stored at the pointer, and then the pointer increments.
- R7: A read carries no sub-address. Bytes are sent MSB first, starting at the current pointer, and the pointer increments after each byte. A write holding only a sub-address sets the start point of the next read.
- R8: During a read, a master ACK (SDA low in the ninth clock) causes the next byte to be sent. A NACK releases SDA and returns the block to idle.
- R9: The pointer wraps from 0xFF to 0x00.
- R10: A START inside a transaction abandons it. A byte only partly received is not stored, and the new address byte is handled normally.
- R11: Reset leaves SDA released and sets the pointer and every register to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | 1 = pull SDA low; 0 = release |
| cfg_multi_id | input | 1 | Strap: 1 selects the eight-address table |
| cfg_id_sel | input | 3 | Strap: address table index |

## Verification
The bench targets the pointer's carry-over between transactions:
- A read that follows a multi-byte write. A design that reset the pointer at START, or reloaded it on reads, would return the wrong byte.
- Wrap-around at 0xFF. A design missing it would read or write past the end of the register file.
- A START injected in the middle of a data byte. A design that stores partial bytes, or ignores the fresh START, would corrupt a register or fail to acknowledge.
- Addresses that do not match, in both strap modes. A design that decodes the straps wrongly would acknowledge a foreign address or write a register it was never addressed for.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } rs_state_e;

    localparam logic [7:0] ID_BASE = 8'hC0;
endpackage

// File: rtl/i2c_rs_sync.sv
module i2c_rs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_ff, sda_ff;
    logic              scl_p, sda_p, scl_s;

    // Bus lines idle high, so every stage resets to 1.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_p  <= scl_ff[STAGES-1];
            sda_p  <= sda_ff[STAGES-1];
        end
    end

    assign scl_s     = scl_ff[STAGES-1];
    assign sda_s     = sda_ff[STAGES-1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_rs_regs.sv
module i2c_rs_regs #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/i2c_rs_ctrl.sv
module i2c_rs_ctrl
    import i2c_rs_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DW    = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic             cfg_multi_id,
    input  logic [SEL_W-1:0] cfg_id_sel,
    input  logic [DW-1:0]    rd_data,
    output logic             wr_en,
    output logic [DW-1:0]    wr_data,
    output logic [AW-1:0]    ptr,
    output rs_state_e        state,
    output logic             sda_oe
);
    localparam int              BW       = $clog2(DW + 1);
    localparam logic [BW-1:0]   LAST_BIT = BW'(DW - 1);
    localparam logic [BW-1:0]   FULL     = BW'(DW);

    rs_state_e       state_q, state_d;
    logic [BW-1:0]   bitcnt_q;
    logic [DW-2:0]   rxsh_q, txsh_q;
    logic [AW-1:0]   ptr_q;
    logic            rw_q, ack_ph_q, oe_q;
    logic [DW-1:0]   rx_byte, id_w;
    logic            rx_state, byte_done, addr_hit, bus_evt;

    assign id_w      = cfg_multi_id ? ID_BASE + DW'({cfg_id_sel, 2'b00}) : ID_BASE;
    assign rx_byte   = {rxsh_q, sda_s};
    assign rx_state  = (state_q == ST_ADDR) || (state_q == ST_SUB) || (state_q == ST_WDATA);
    assign byte_done = rx_state && scl_rise && (bitcnt_q == LAST_BIT);
    assign addr_hit  = rx_byte[DW-1:1] == id_w[DW-1:1];
    assign bus_evt   = start_det || stop_det;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (start_det)     state_d = ST_ADDR;
        else if (stop_det) state_d = ST_IDLE;
        else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_ADDR:      if (byte_done) state_d = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK:  if (scl_fall && ack_ph_q) state_d = rw_q ? ST_RDATA : ST_SUB;
                ST_SUB:       if (byte_done) state_d = ST_SUB_ACK;
                ST_SUB_ACK:   if (scl_fall && ack_ph_q) state_d = ST_WDATA;
                ST_WDATA:     if (byte_done) state_d = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall && ack_ph_q) state_d = ST_WDATA;
                ST_RDATA:     if (scl_fall && bitcnt_q == FULL) state_d = ST_RACK;
                ST_RACK: begin
                    if (scl_rise && sda_s)          state_d = ST_IDLE;
                    else if (scl_fall && ack_ph_q)  state_d = ST_RDATA;
                end
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt_q <= '0;
            rxsh_q   <= '0;
            txsh_q   <= '0;
            ptr_q    <= '0;
            rw_q     <= 1'b0;
            ack_ph_q <= 1'b0;
            oe_q     <= 1'b0;
        end else if (bus_evt) begin
            bitcnt_q <= '0;
            ack_ph_q <= 1'b0;
            oe_q     <= 1'b0;
        end else begin
            unique case (state_q)
                ST_ADDR, ST_SUB, ST_WDATA: begin
                    if (scl_rise) begin
                        rxsh_q   <= rx_byte[DW-2:0];
                        bitcnt_q <= bitcnt_q + 1'b1;
                    end
                    if (byte_done) begin
                        bitcnt_q <= '0;
                        ack_ph_q <= 1'b0;
                        if (state_q == ST_ADDR)  rw_q  <= rx_byte[0];
                        if (state_q == ST_SUB)   ptr_q <= rx_byte[AW-1:0];
                        if (state_q == ST_WDATA) ptr_q <= ptr_q + 1'b1;
                    end
                end
                ST_ADDR_ACK, ST_SUB_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        if (!ack_ph_q) begin
                            oe_q     <= 1'b1;
                            ack_ph_q <= 1'b1;
                        end else begin
                            ack_ph_q <= 1'b0;
                            if (state_q == ST_ADDR_ACK && rw_q) begin
                                txsh_q   <= rd_data[DW-2:0];
                                oe_q     <= ~rd_data[DW-1];
                                bitcnt_q <= '0;
                            end else begin
                                oe_q <= 1'b0;
                            end
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) bitcnt_q <= bitcnt_q + 1'b1;
                    if (scl_fall) begin
                        if (bitcnt_q == FULL) begin
                            oe_q     <= 1'b0;
                            bitcnt_q <= '0;
                            ack_ph_q <= 1'b0;
                            ptr_q    <= ptr_q + 1'b1;
                        end else begin
                            oe_q   <= ~txsh_q[DW-2];
                            txsh_q <= txsh_q << 1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise && !sda_s) ack_ph_q <= 1'b1;
                    if (scl_fall && ack_ph_q) begin
                        txsh_q   <= rd_data[DW-2:0];
                        oe_q     <= ~rd_data[DW-1];
                        bitcnt_q <= '0;
                        ack_ph_q <= 1'b0;
                    end
                end
                default: oe_q <= 1'b0;
            endcase
        end
    end

    assign wr_en   = (state_q == ST_WDATA) && byte_done && !bus_evt;
    assign wr_data = rx_byte;
    assign ptr     = ptr_q;
    assign state   = state_q;
    assign sda_oe  = oe_q;
endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave
    import i2c_rs_pkg::*;
#(
    parameter int AW          = 8,
    parameter int DW          = 8,
    parameter int SEL_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic             cfg_multi_id,
    input  logic [SEL_W-1:0] cfg_id_sel
);
    logic          sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic          wr_en;
    logic [DW-1:0] wr_data, rd_data;
    logic [AW-1:0] ptr;
    rs_state_e     ctl_state;

    i2c_rs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_rs_ctrl #(.AW(AW), .DW(DW), .SEL_W(SEL_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .sda_s        (sda_s),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall),
        .start_det    (start_det),
        .stop_det     (stop_det),
        .cfg_multi_id (cfg_multi_id),
        .cfg_id_sel   (cfg_id_sel),
        .rd_data      (rd_data),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .ptr          (ptr),
        .state        (ctl_state),
        .sda_oe       (sda_oe)
    );

    i2c_rs_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .addr  (ptr),
        .wdata (wr_data),
        .rdata (rd_data)
    );
endmodule

// File: rtl/i2c_regslave_chk.sv
module i2c_regslave_chk
    import i2c_rs_pkg::*;
#(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input rs_state_e     state,
    input logic [AW-1:0] ptr,
    input logic          sda_oe,
    input logic          scl_fall,
    input logic          start_det,
    input logic          stop_det
);
    // R1: STOP leaves the block idle with SDA released
    a_r1_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE) && !sda_oe);

    // R10: START always restarts address reception
    a_r10_start_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> state == ST_ADDR);

    // R4: idle (including after a mismatch) never pulls SDA
    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

    // R5: SDA drive changes only while SCL is low (after a fall) or on a bus event
    a_r5_oe_on_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));

    // R9: the pointer either loads from the sub-address or steps by one, wrapping
    a_r9_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr != $past(ptr)) |-> (((ptr - $past(ptr)) == AW'(1)) || ($past(state) == ST_SUB)));
endmodule

bind i2c_regslave i2c_regslave_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (ctl_state),
    .ptr       (ptr),
    .sda_oe    (sda_oe),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
);

// File: tb/i2c_regslave_test.sv
module i2c_regslave_test;
    localparam int Q = 10;   // system clocks per quarter SCL period

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic       cfg_multi_id = 1'b0;
    logic [2:0] cfg_id_sel = 3'd0;
    logic       sda_bus;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    string exp_req_q[$];
    int    exp_val_q[$];
    int    act_q[$];

    assign sda_bus = sda_m & ~sda_oe;

    always #10 clk = ~clk;   // 50 MHz

    i2c_regslave uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_m),
        .sda_i        (sda_bus),
        .sda_oe       (sda_oe),
        .cfg_multi_id (cfg_multi_id),
        .cfg_id_sel   (cfg_id_sel)
    );

    // Scoreboard monitor: pairs observed results with expected items
    initial begin
        forever begin
            @(negedge clk);
            while (act_q.size() > 0 && exp_val_q.size() > 0) begin
                string r;
                int e, a;
                r = exp_req_q.pop_front();
                e = exp_val_q.pop_front();
                a = act_q.pop_front();
                n_cmp++;
                if (a != e) begin
                    n_bad++;
                    $display("FAIL %s: actual 0x%0h expected 0x%0h", r, a, e);
                end
            end
        end
    end

    task automatic expect_val(input string req, input int v);
        exp_req_q.push_back(req);
        exp_val_q.push_back(v);
    endtask

    task automatic observe(input int v);
        act_q.push_back(v);
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic put_bit(input bit b);
        sda_m = b; wq();
        scl_m = 1'b1; wq(); wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic get_bit(output bit b);
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        b = sda_bus; wq();
        scl_m = 1'b0; wq();
    endtask

    // Sends a byte MSB first; records whether the slave acknowledged.
    task automatic send_byte(input string req, input logic [7:0] v, input bit exp_ack);
        bit b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        expect_val(req, int'(exp_ack));
        observe(int'(!b));
    endtask

    // Receives a byte MSB first and answers with ACK or NACK.
    task automatic recv_byte(input string req, input logic [7:0] exp_v, input bit m_ack);
        logic [7:0] v;
        bit b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(!m_ack);
        expect_val(req, int'(exp_v));
        observe(int'(v));
    endtask

    task automatic set_ptr(input logic [7:0] wid, input logic [7:0] sub);
        bus_start();
        send_byte("R7 ptr-load addr", wid, 1'b1);
        send_byte("R7 ptr-load sub", sub, 1'b1);
        bus_stop();
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R11: reset state
        expect_val("R11 sda released in reset", 0);
        observe(int'(sda_oe));
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 R2 R5 R6: write sub 0x10, three data bytes
        bus_start();
        send_byte("R1 R2 write addr C0 ack", 8'hC0, 1'b1);
        send_byte("R5 sub ack", 8'h10, 1'b1);
        send_byte("R6 data A5 ack", 8'hA5, 1'b1);
        send_byte("R6 data 3C ack", 8'h3C, 1'b1);
        send_byte("R6 data 7E ack", 8'h7E, 1'b1);
        bus_stop();
        expect_val("R1 sda released after stop", 0);
        observe(int'(sda_oe));

        // R7 R11: read continues from the advanced pointer 0x13 (reset contents)
        bus_start();
        send_byte("R2 read addr C1 ack", 8'hC1, 1'b1);
        recv_byte("R7 R11 read at 0x13", 8'h00, 1'b0);
        expect_val("R8 sda released after nack", 0);
        observe(int'(sda_oe));
        bus_stop();

        // R7 R8: reload pointer with a sub-only write, read three bytes back
        set_ptr(8'hC0, 8'h10);
        bus_start();
        send_byte("R7 read addr", 8'hC1, 1'b1);
        recv_byte("R7 R8 byte0", 8'hA5, 1'b1);
        recv_byte("R7 R8 byte1", 8'h3C, 1'b1);
        recv_byte("R7 R8 byte2", 8'h7E, 1'b0);
        bus_stop();

        // R9: wrap at 0xFF on write and read
        bus_start();
        send_byte("R9 addr", 8'hC0, 1'b1);
        send_byte("R9 sub FF", 8'hFF, 1'b1);
        send_byte("R9 data at FF", 8'h11, 1'b1);
        send_byte("R9 data at 00", 8'h22, 1'b1);
        bus_stop();
        set_ptr(8'hC0, 8'hFF);
        bus_start();
        send_byte("R9 read addr", 8'hC1, 1'b1);
        recv_byte("R9 read FF", 8'h11, 1'b1);
        recv_byte("R9 read 00 after wrap", 8'h22, 1'b0);
        bus_stop();

        // R4: mismatched address is ignored
        bus_start();
        send_byte("R4 R2 addr C4 nack", 8'hC4, 1'b0);
        send_byte("R4 no ack sub", 8'h50, 1'b0);
        send_byte("R4 no ack data", 8'h99, 1'b0);
        bus_stop();
        set_ptr(8'hC0, 8'h50);
        bus_start();
        send_byte("R4 read addr", 8'hC1, 1'b1);
        recv_byte("R4 register 0x50 untouched", 8'h00, 1'b0);
        bus_stop();

        // R10: START in the middle of a data byte
        bus_start();
        send_byte("R10 addr", 8'hC0, 1'b1);
        send_byte("R10 sub 40", 8'h40, 1'b1);
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        bus_start();
        send_byte("R10 fresh start addr ack", 8'hC0, 1'b1);
        send_byte("R10 sub 40 again", 8'h40, 1'b1);
        bus_stop();
        bus_start();
        send_byte("R10 read addr", 8'hC1, 1'b1);
        recv_byte("R10 partial byte not stored", 8'h00, 1'b0);
        bus_stop();

        // R3: strap-selected address table, sel = 5 -> D4/D5
        cfg_multi_id = 1'b1;
        cfg_id_sel   = 3'd5;
        repeat (4) @(negedge clk);
        bus_start();
        send_byte("R3 C0 rejected in multi mode", 8'hC0, 1'b0);
        bus_stop();
        bus_start();
        send_byte("R3 write addr D4", 8'hD4, 1'b1);
        send_byte("R3 sub 20", 8'h20, 1'b1);
        send_byte("R3 data 5A", 8'h5A, 1'b1);
        bus_stop();
        set_ptr(8'hD4, 8'h20);
        bus_start();
        send_byte("R3 read addr D5", 8'hD5, 1'b1);
        recv_byte("R3 read back 5A", 8'h5A, 1'b0);
        bus_stop();

        repeat (20) @(negedge clk);
        if (exp_val_q.size() != 0 || act_q.size() != 0) begin
            n_cmp++;
            n_bad++;
            $display("FAIL scoreboard: actual %0d leftover expected 0", exp_val_q.size() + act_q.size());
        end
        done = 1'b1;
        report();
        $finish;
    end
endmodule